// File: doc/BRIEF.md
# Multi-Source Interrupt Distributor

This block gathers interrupt requests from three source classes, keeps a lifecycle state for each one, and presents to every attached CPU interface the single most urgent request that the CPU may take. IDs 0 to 15 are raised by a configuration write. IDs 16 to 31 are private per-CPU lines. IDs from 32 upward are shared peripheral lines. Each CPU holds its own copy of IDs 0 to 31. The shared IDs have a single copy and are routed by a per-source CPU mask.

Each source moves through four states: inactive, pending, active, and active-and-pending. A CPU interface acknowledges the request it is shown, and the request becomes active. Later the CPU writes an end-of-interrupt with the ID, and the request leaves the active state. Configuration uses a write-only port. The port carries a 3-bit kind code, an ID and a data word. Priorities are 8 bits, and a lower value is more urgent. The asynchronous active-low reset is released synchronously through two internal flops.

Top module: `irqd_top`

## Requirements
- R1: While reset is applied, and whenever no request qualifies, each CPU's `cpu_valid` is 0. Whenever `cpu_valid` is 0, `cpu_id`, `cpu_prio` and `cpu_grp` read 0.
- R2: Kind 0 writes the global enable from `cfg_wdata[0]` (reset 0). While it is 0 no CPU shows a request. Pending state is kept and reappears once the enable is set again.
- R3: Kind 1 writes the enable of source `cfg_id` from `cfg_wdata[0]` (reset 0). A disabled source is never shown, and other sources are unaffected.
- R4: Kind 2 writes the priority of `cfg_id` from `cfg_wdata[7:0]` (reset 0). Each CPU shows the eligible request with the smallest priority value. On equal values the lower ID wins.
- R5: A kind 6 write with `cfg_id` below 16 makes that ID pending in the copy of every CPU c whose bit `cfg_wdata[c]` is 1. Each copy is seen only by its own CPU.
- R6: ID 16+k of CPU c follows `ppi_n[c*16+k]`, which is active low and level sensitive. The pending state equals the line value sampled at the previous clock edge, and only CPU c sees it.
- R7: Shared ID 32+j is driven by `spi_in[j]`. Kind 3 with `cfg_wdata[0]`=1 selects edge mode, in which a rising edge latches pending. With 0 (the reset value) the source is level-high mode, and pending follows the line one edge later. Kind 7 clears the latched pending of an edge or software source; for an ID below 16 it clears the copies of all CPUs. Kind 7 has no effect on a level source.
- R8: Kind 5 writes the CPU mask of a shared ID from `cfg_wdata[NUM_CPU-1:0]` (reset 0). Bit c allows CPU c to see the ID. Kinds 3 and 5 are ignored for IDs below 32.
- R9: `cpu_ack[c]` while `cpu_valid[c]` is 1 raises `cpu_ack_ok[c]` in the same cycle. At the next edge the shown request becomes active, stops being shown, and drops any latched pending.
- R10: A new event on an active source makes it active-and-pending, and it is not shown. `cpu_eoi[c]` with `cpu_eoi_id[c]` ends the active state. An active-and-pending source then returns to pending and is shown again.
- R11: An end-of-interrupt for an ID below 32 acts only on the copy of the issuing CPU. An end-of-interrupt for a source that is not active changes nothing.
- R12: A shared request routed to several CPUs becomes active for the first CPU that acknowledges it, and is then withdrawn from all of them. If several CPUs acknowledge it in the same cycle, the lowest-numbered CPU wins and the others see `cpu_ack_ok` at 0.
- R13: Kind 4 writes the group of `cfg_id` from `cfg_wdata[0]`. `cpu_grp` carries the group of the request that is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Write kind: 0 global enable, 1 enable, 2 priority, 3 trigger, 4 group, 5 CPU mask, 6 raise software ID, 7 clear pending |
| cfg_id | input | ID_W | Target interrupt ID of the write |
| cfg_wdata | input | CFG_W | Write data |
| ppi_n | input | NUM_CPU*16 | Private active-low level lines, 16 per CPU |
| spi_in | input | NUM_SHARED | Shared peripheral lines |
| cpu_ack | input | NUM_CPU | Acknowledge strobe per CPU |
| cpu_eoi | input | NUM_CPU | End-of-interrupt strobe per CPU |
| cpu_eoi_id | input | NUM_CPU x ID_W | ID being completed per CPU |
| cpu_valid | output | NUM_CPU | A request is shown to the CPU |
| cpu_id | output | NUM_CPU x ID_W | ID of the shown request |
| cpu_prio | output | NUM_CPU x 8 | Priority of the shown request |
| cpu_grp | output | NUM_CPU | Group of the shown request |
| cpu_ack_ok | output | NUM_CPU | Acknowledge accepted this cycle |

## Verification
The assertions check several rules on every cycle. A shown request must be pending, not active, and passed by the global enable. Idle outputs must read zero. An accepted acknowledge must make its source active, and an end-of-interrupt must clear the active state. Two CPUs may never both win one shared ID. Only the directed scenarios can show priority order, tie breaking, class-specific triggering, mask routing, per-CPU banking of the low IDs, and the re-presentation of an active-and-pending source after its end-of-interrupt. The bench checks these against its behavioural model.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int PRIO_W  = 8;
  localparam int PRV_IDS = 32;
  localparam int SW_IDS  = 16;

  typedef enum logic [2:0] {
    K_GLOBAL = 3'd0,
    K_ENABLE = 3'd1,
    K_PRIO   = 3'd2,
    K_EDGE   = 3'd3,
    K_GROUP  = 3'd4,
    K_TARGET = 3'd5,
    K_RAISE  = 3'd6,
    K_CLEAR  = 3'd7
  } cfg_kind_e;

  // Private IDs are banked per CPU; shared IDs follow all private slots.
  function automatic int slot_of(input int ncpu, input int cpu, input int id);
    return (id < PRV_IDS) ? cpu * PRV_IDS + id : ncpu * PRV_IDS + id - PRV_IDS;
  endfunction
endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg
  import irqd_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_SHARED = 32,
  parameter int CFG_W      = 8,
  localparam int NUM_ID    = PRV_IDS + NUM_SHARED,
  localparam int ID_W      = $clog2(NUM_ID)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [2:0]                          cfg_kind,
  input  logic [ID_W-1:0]                     cfg_id,
  input  logic [CFG_W-1:0]                    cfg_wdata,
  output logic                                glob_en,
  output logic [NUM_ID-1:0]                   src_en,
  output logic [NUM_ID-1:0][PRIO_W-1:0]       src_prio,
  output logic [NUM_ID-1:0]                   src_grp,
  output logic [NUM_SHARED-1:0]               shr_edge,
  output logic [NUM_SHARED-1:0][NUM_CPU-1:0]  shr_tgt,
  output logic                                raise_fire,
  output logic                                clear_fire,
  output logic [NUM_CPU-1:0]                  raise_tgt
);
  logic                               glob_en_n;
  logic [NUM_ID-1:0]                  en_n;
  logic [NUM_ID-1:0][PRIO_W-1:0]      prio_n;
  logic [NUM_ID-1:0]                  grp_n;
  logic [NUM_SHARED-1:0]              edge_n;
  logic [NUM_SHARED-1:0][NUM_CPU-1:0] tgt_n;
  cfg_kind_e                          kind;
  int                                 id_i;

  assign kind       = cfg_kind_e'(cfg_kind);
  assign id_i       = int'(cfg_id);
  assign raise_fire = cfg_we && (kind == K_RAISE) && (id_i < SW_IDS);
  assign clear_fire = cfg_we && (kind == K_CLEAR) && (id_i < NUM_ID);
  assign raise_tgt  = cfg_wdata[NUM_CPU-1:0];

  always_comb begin
    glob_en_n = glob_en;
    en_n      = src_en;
    prio_n    = src_prio;
    grp_n     = src_grp;
    edge_n    = shr_edge;
    tgt_n     = shr_tgt;
    if (cfg_we && id_i < NUM_ID) begin
      case (kind)
        K_GLOBAL: glob_en_n    = cfg_wdata[0];
        K_ENABLE: en_n[id_i]   = cfg_wdata[0];
        K_PRIO:   prio_n[id_i] = cfg_wdata[PRIO_W-1:0];
        K_GROUP:  grp_n[id_i]  = cfg_wdata[0];
        K_EDGE:   if (id_i >= PRV_IDS) edge_n[id_i-PRV_IDS] = cfg_wdata[0];
        K_TARGET: if (id_i >= PRV_IDS) tgt_n[id_i-PRV_IDS] = cfg_wdata[NUM_CPU-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      src_en   <= '0;
      src_prio <= '0;
      src_grp  <= '0;
      shr_edge <= '0;
      shr_tgt  <= '0;
    end else if (cfg_we) begin
      glob_en  <= glob_en_n;
      src_en   <= en_n;
      src_prio <= prio_n;
      src_grp  <= grp_n;
      shr_edge <= edge_n;
      shr_tgt  <= tgt_n;
    end
  end
endmodule

// File: rtl/irqd_src.sv
module irqd_src (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic line,
  input  logic set_evt,
  input  logic clr,
  input  logic ack,
  input  logic eoi,
  output logic pend,
  output logic act
);
  logic line_q;
  logic pend_n;
  logic act_n;
  logic evt;
  logic take;

  assign evt  = set_evt | (edge_mode & line & ~line_q);
  assign take = ack & pend & ~act;

  always_comb begin
    if (edge_mode) begin
      pend_n = pend;
      if (take) pend_n = 1'b0;
      if (clr)  pend_n = 1'b0;
      if (evt)  pend_n = 1'b1;
    end else begin
      pend_n = line;
    end
    act_n = act;
    if (eoi)  act_n = 1'b0;
    if (take) act_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
      act    <= 1'b0;
    end else begin
      line_q <= line;
      pend   <= pend_n;
      act    <= act_n;
    end
  end
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
  import irqd_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_SHARED = 32,
  parameter int CPU_IDX    = 0,
  localparam int NUM_ID    = PRV_IDS + NUM_SHARED,
  localparam int NUM_SLOT  = NUM_CPU * PRV_IDS + NUM_SHARED,
  localparam int ID_W      = $clog2(NUM_ID)
) (
  input  logic                                glob_en,
  input  logic [NUM_ID-1:0]                   src_en,
  input  logic [NUM_ID-1:0][PRIO_W-1:0]       src_prio,
  input  logic [NUM_ID-1:0]                   src_grp,
  input  logic [NUM_SHARED-1:0][NUM_CPU-1:0]  shr_tgt,
  input  logic [NUM_SLOT-1:0]                 slot_pend,
  input  logic [NUM_SLOT-1:0]                 slot_act,
  output logic                                sel_valid,
  output logic [ID_W-1:0]                     sel_id,
  output logic [PRIO_W-1:0]                   sel_prio,
  output logic                                sel_grp
);
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    sel_prio  = '0;
    sel_grp   = 1'b0;
    for (int i = 0; i < NUM_ID; i++) begin
      logic routed;
      logic elig;
      int   s;
      s      = slot_of(NUM_CPU, CPU_IDX, i);
      routed = 1'b1;
      if (i >= PRV_IDS) routed = shr_tgt[i-PRV_IDS][CPU_IDX];
      elig = glob_en & src_en[i] & slot_pend[s] & ~slot_act[s] & routed;
      if (elig && (!sel_valid || src_prio[i] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(i);
        sel_prio  = src_prio[i];
        sel_grp   = src_grp[i];
      end
    end
  end
endmodule

// File: rtl/irqd_top.sv
module irqd_top
  import irqd_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_SHARED = 32,
  parameter int CFG_W      = 8,
  localparam int NUM_ID    = PRV_IDS + NUM_SHARED,
  localparam int ID_W      = $clog2(NUM_ID)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [2:0]                       cfg_kind,
  input  logic [ID_W-1:0]                  cfg_id,
  input  logic [CFG_W-1:0]                 cfg_wdata,
  input  logic [NUM_CPU*16-1:0]            ppi_n,
  input  logic [NUM_SHARED-1:0]            spi_in,
  input  logic [NUM_CPU-1:0]               cpu_ack,
  input  logic [NUM_CPU-1:0]               cpu_eoi,
  input  logic [NUM_CPU-1:0][ID_W-1:0]     cpu_eoi_id,
  output logic [NUM_CPU-1:0]               cpu_valid,
  output logic [NUM_CPU-1:0][ID_W-1:0]     cpu_id,
  output logic [NUM_CPU-1:0][PRIO_W-1:0]   cpu_prio,
  output logic [NUM_CPU-1:0]               cpu_grp,
  output logic [NUM_CPU-1:0]               cpu_ack_ok
);
  localparam int PRV_SLOTS = NUM_CPU * PRV_IDS;
  localparam int NUM_SLOT  = PRV_SLOTS + NUM_SHARED;

  logic [1:0]                         rst_pipe;
  logic                               rst_int_n;
  logic                               glob_en;
  logic [NUM_ID-1:0]                  src_en;
  logic [NUM_ID-1:0][PRIO_W-1:0]      src_prio;
  logic [NUM_ID-1:0]                  src_grp;
  logic [NUM_SHARED-1:0]              shr_edge;
  logic [NUM_SHARED-1:0][NUM_CPU-1:0] shr_tgt;
  logic                               raise_fire;
  logic                               clear_fire;
  logic [NUM_CPU-1:0]                 raise_tgt;
  logic [NUM_SLOT-1:0]                slot_pend;
  logic [NUM_SLOT-1:0]                slot_act;
  logic [NUM_SLOT-1:0]                ack_vec;
  logic [NUM_SLOT-1:0]                eoi_vec;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  irqd_cfg #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_id(cfg_id), .cfg_wdata(cfg_wdata), .glob_en(glob_en), .src_en(src_en),
    .src_prio(src_prio), .src_grp(src_grp), .shr_edge(shr_edge), .shr_tgt(shr_tgt),
    .raise_fire(raise_fire), .clear_fire(clear_fire), .raise_tgt(raise_tgt)
  );

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic em, ln, se, cl;
    if (s < PRV_SLOTS && (s % PRV_IDS) < SW_IDS) begin : g_sw
      localparam int C = s / PRV_IDS;
      localparam int I = s % PRV_IDS;
      assign em = 1'b1;
      assign ln = 1'b0;
      assign se = raise_fire && (int'(cfg_id) == I) && raise_tgt[C];
      assign cl = clear_fire && (int'(cfg_id) == I);
    end else if (s < PRV_SLOTS) begin : g_prv
      localparam int C = s / PRV_IDS;
      localparam int K = (s % PRV_IDS) - SW_IDS;
      assign em = 1'b0;
      assign ln = ~ppi_n[C*16+K];
      assign se = 1'b0;
      assign cl = 1'b0;
    end else begin : g_shr
      localparam int J = s - PRV_SLOTS;
      assign em = shr_edge[J];
      assign ln = spi_in[J];
      assign se = 1'b0;
      assign cl = clear_fire && (int'(cfg_id) == PRV_IDS + J);
    end
    irqd_src u_src (
      .clk(clk), .rst_n(rst_int_n), .edge_mode(em), .line(ln), .set_evt(se),
      .clr(cl), .ack(ack_vec[s]), .eoi(eoi_vec[s]),
      .pend(slot_pend[s]), .act(slot_act[s])
    );
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irqd_arb #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED), .CPU_IDX(c)) u_arb (
      .glob_en(glob_en), .src_en(src_en), .src_prio(src_prio), .src_grp(src_grp),
      .shr_tgt(shr_tgt), .slot_pend(slot_pend), .slot_act(slot_act),
      .sel_valid(cpu_valid[c]), .sel_id(cpu_id[c]), .sel_prio(cpu_prio[c]),
      .sel_grp(cpu_grp[c])
    );
  end

  // Acknowledge arbitration: on a shared ID the lowest-numbered CPU wins.
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      cpu_ack_ok[c] = cpu_ack[c] & cpu_valid[c];
      for (int d = 0; d < NUM_CPU; d++) begin
        if (d < c && cpu_ack[d] && cpu_valid[d] && cpu_id[d] == cpu_id[c]
            && int'(cpu_id[c]) >= PRV_IDS)
          cpu_ack_ok[c] = 1'b0;
      end
    end
  end

  always_comb begin
    ack_vec = '0;
    eoi_vec = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_ack_ok[c]) ack_vec[slot_of(NUM_CPU, c, int'(cpu_id[c]))] = 1'b1;
      if (cpu_eoi[c] && int'(cpu_eoi_id[c]) < NUM_ID)
        eoi_vec[slot_of(NUM_CPU, c, int'(cpu_eoi_id[c]))] = 1'b1;
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
  import irqd_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_SHARED = 32,
  localparam int NUM_ID    = PRV_IDS + NUM_SHARED,
  localparam int NUM_SLOT  = NUM_CPU * PRV_IDS + NUM_SHARED,
  localparam int ID_W      = $clog2(NUM_ID)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            glob_en,
  input logic [NUM_SLOT-1:0]             slot_pend,
  input logic [NUM_SLOT-1:0]             slot_act,
  input logic [NUM_CPU-1:0]              cpu_ack,
  input logic [NUM_CPU-1:0]              cpu_eoi,
  input logic [NUM_CPU-1:0][ID_W-1:0]    cpu_eoi_id,
  input logic [NUM_CPU-1:0]              cpu_valid,
  input logic [NUM_CPU-1:0][ID_W-1:0]    cpu_id,
  input logic [NUM_CPU-1:0][PRIO_W-1:0]  cpu_prio,
  input logic [NUM_CPU-1:0]              cpu_grp,
  input logic [NUM_CPU-1:0]              cpu_ack_ok
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid[c] |-> (cpu_id[c] == '0 && cpu_prio[c] == '0 && !cpu_grp[c]));
    p_gate_global_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid[c] |-> glob_en);
    p_shown_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid[c] |-> (slot_pend[slot_of(NUM_CPU, c, int'(cpu_id[c]))]
                        && !slot_act[slot_of(NUM_CPU, c, int'(cpu_id[c]))]));
    p_ok_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack_ok[c] |-> (cpu_ack[c] && cpu_valid[c]));
    p_ack_activates_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack_ok[c] |=> slot_act[slot_of(NUM_CPU, c, int'($past(cpu_id[c])))]);
    p_eoi_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_eoi[c] && cpu_ack_ok == '0 && int'(cpu_eoi_id[c]) < NUM_ID)
        |=> !slot_act[slot_of(NUM_CPU, c, int'($past(cpu_eoi_id[c])))]);
    for (genvar d = c + 1; d < NUM_CPU; d++) begin : g_d
      p_one_winner_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_ok[c] && cpu_ack_ok[d])
          |-> (int'(cpu_id[c]) < PRV_IDS || cpu_id[c] != cpu_id[d]));
    end
  end
endmodule

bind irqd_top irqd_chk #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .glob_en(glob_en), .slot_pend(slot_pend),
  .slot_act(slot_act), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id),
  .cpu_valid(cpu_valid), .cpu_id(cpu_id), .cpu_prio(cpu_prio), .cpu_grp(cpu_grp),
  .cpu_ack_ok(cpu_ack_ok)
);

// File: tb/tb_irqd_top.sv
module tb_irqd_top;
  localparam int NC = 2;
  localparam int NS = 32;
  localparam int NID = 32 + NS;
  localparam int IDW = $clog2(NID);
  localparam int NSLOT = NC * 32 + NS;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [2:0] cfg_kind;
  logic [IDW-1:0] cfg_id;
  logic [7:0] cfg_wdata;
  logic [NC*16-1:0] ppi_n;
  logic [NS-1:0] spi_in;
  logic [NC-1:0] cpu_ack, cpu_eoi;
  logic [NC-1:0][IDW-1:0] cpu_eoi_id;
  logic [NC-1:0] cpu_valid, cpu_grp, cpu_ack_ok;
  logic [NC-1:0][IDW-1:0] cpu_id;
  logic [NC-1:0][7:0] cpu_prio;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  irqd_top #(.NUM_CPU(NC), .NUM_SHARED(NS), .CFG_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_id(cfg_id),
    .cfg_wdata(cfg_wdata), .ppi_n(ppi_n), .spi_in(spi_in), .cpu_ack(cpu_ack),
    .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id), .cpu_valid(cpu_valid), .cpu_id(cpu_id),
    .cpu_prio(cpu_prio), .cpu_grp(cpu_grp), .cpu_ack_ok(cpu_ack_ok)
  );

  // ---------------- behavioural reference model ----------------
  bit ge;
  bit en[NID];
  int pr[NID];
  bit gr[NID];
  bit edg[NS];
  bit [NC-1:0] tg[NS];
  bit mp[NSLOT];
  bit ma[NSLOT];
  bit mlq[NSLOT];

  function automatic int sl(input int c, input int id);
    if (id < 32) return c * 32 + id;
    return NC * 32 + id - 32;
  endfunction

  function automatic void best(input int c, output bit v, output int id,
                               output int p, output bit g);
    v = 0; id = 0; p = 0; g = 0;
    for (int i = 0; i < NID; i++) begin
      bit r;
      int s;
      s = sl(c, i);
      r = (i < 32) ? 1'b1 : tg[i-32][c];
      if (ge && en[i] && mp[s] && !ma[s] && r && (!v || pr[i] < p)) begin
        v = 1; id = i; p = pr[i]; g = gr[i];
      end
    end
  endfunction

  function automatic bit [NC-1:0] exp_ok();
    bit [NC-1:0] ok;
    int ids[NC];
    bit vs[NC];
    for (int c = 0; c < NC; c++) begin
      int p;
      bit g;
      best(c, vs[c], ids[c], p, g);
      ok[c] = cpu_ack[c] && vs[c];
      for (int d = 0; d < c; d++)
        if (ok[d] && ids[d] == ids[c] && ids[c] >= 32) ok[c] = 0;
    end
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge = 0;
      for (int i = 0; i < NID; i++) begin en[i] = 0; pr[i] = 0; gr[i] = 0; end
      for (int j = 0; j < NS; j++) begin edg[j] = 0; tg[j] = '0; end
      for (int s = 0; s < NSLOT; s++) begin mp[s] = 0; ma[s] = 0; mlq[s] = 0; end
    end else begin : upd
      bit [NC-1:0] ok;
      bit ackv[NSLOT];
      bit eoiv[NSLOT];
      int wid;
      ok = exp_ok();
      wid = int'(cfg_id);
      for (int s = 0; s < NSLOT; s++) begin ackv[s] = 0; eoiv[s] = 0; end
      for (int c = 0; c < NC; c++) begin
        bit v; int id; int p; bit g;
        best(c, v, id, p, g);
        if (ok[c]) ackv[sl(c, id)] = 1;
        if (cpu_eoi[c]) eoiv[sl(c, int'(cpu_eoi_id[c]))] = 1;
      end
      for (int s = 0; s < NSLOT; s++) begin
        bit em, ln, ev, cl, evt, take;
        if (s < NC * 32) begin
          int c, i;
          c = s / 32; i = s % 32;
          if (i < 16) begin
            em = 1; ln = 0;
            ev = cfg_we && cfg_kind == 3'd6 && wid == i && cfg_wdata[c];
            cl = cfg_we && cfg_kind == 3'd7 && wid == i;
          end else begin
            em = 0; ln = !ppi_n[c*16+i-16]; ev = 0; cl = 0;
          end
        end else begin
          int j;
          j = s - NC * 32;
          em = edg[j]; ln = spi_in[j]; ev = 0;
          cl = cfg_we && cfg_kind == 3'd7 && wid == 32 + j;
        end
        evt = ev || (em && ln && !mlq[s]);
        take = ackv[s] && mp[s] && !ma[s];
        mlq[s] = ln;
        if (em) begin
          if (take) mp[s] = 0;
          if (cl) mp[s] = 0;
          if (evt) mp[s] = 1;
        end else mp[s] = ln;
        if (eoiv[s]) ma[s] = 0;
        if (take) ma[s] = 1;
      end
      if (cfg_we) begin
        case (cfg_kind)
          3'd0: ge = cfg_wdata[0];
          3'd1: en[wid] = cfg_wdata[0];
          3'd2: pr[wid] = int'(cfg_wdata);
          3'd3: if (wid >= 32) edg[wid-32] = cfg_wdata[0];
          3'd4: gr[wid] = cfg_wdata[0];
          3'd5: if (wid >= 32) tg[wid-32] = cfg_wdata[NC-1:0];
          default: ;
        endcase
      end
    end
  end

  // Compare the design with the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit [NC-1:0] ok;
      ok = exp_ok();
      for (int c = 0; c < NC; c++) begin
        bit v; int id; int p; bit g;
        best(c, v, id, p, g);
        checks++;
        if (cpu_valid[c] !== v || int'(cpu_id[c]) != id || int'(cpu_prio[c]) != p
            || cpu_grp[c] !== g || cpu_ack_ok[c] !== ok[c]) begin
          errors++;
          $display("FAIL %s cpu%0d v/id/pr/g/ok %0b/%0d/%0d/%0b/%0b expected %0b/%0d/%0d/%0b/%0b",
                   cur_req, c, cpu_valid[c], cpu_id[c], cpu_prio[c], cpu_grp[c],
                   cpu_ack_ok[c], v, id, p, g, ok[c]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int kind, input int id, input int data);
    cfg_we = 1; cfg_kind = 3'(kind); cfg_id = IDW'(id); cfg_wdata = 8'(data);
    step(1);
    cfg_we = 0;
  endtask

  task automatic expect_cand(input int c, input bit v, input int id, input string tag);
    checks++;
    if (cpu_valid[c] !== v || (v && int'(cpu_id[c]) != id)) begin
      errors++;
      $display("FAIL %s cpu%0d valid/id %0b/%0d expected %0b/%0d",
               tag, c, cpu_valid[c], cpu_id[c], v, id);
    end
  endtask

  task automatic expect_bit(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s value %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pulse_spi(input int j);
    spi_in[j] = 1; step(1);
    spi_in[j] = 0; step(1);
  endtask

  task automatic ack(input bit [NC-1:0] m);
    cpu_ack = m; step(1); cpu_ack = '0;
  endtask

  task automatic eoi(input int c, input int id);
    cpu_eoi[c] = 1; cpu_eoi_id[c] = IDW'(id); step(1); cpu_eoi = '0;
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_kind = '0; cfg_id = '0; cfg_wdata = '0;
    ppi_n = '1; spi_in = '0; cpu_ack = '0; cpu_eoi = '0; cpu_eoi_id = '0;
    step(3);
    // R1: idle outputs in reset
    for (int c = 0; c < NC; c++) begin
      expect_cand(c, 0, 0, "R1");
      expect_bit(cpu_prio[c] == 0 && cpu_grp[c] == 0, 1, "R1 zero fields");
    end
    rst_n = 1;
    step(4);
    wr(0, 0, 1);
    wr(1, 3, 1);
    wr(2, 3, 8'h40);

    cur_req = "R5";  // software ID per CPU copy
    wr(6, 3, 2'b01);
    expect_cand(0, 1, 3, "R5");
    expect_cand(1, 0, 0, "R5");
    wr(6, 3, 2'b10);
    expect_cand(1, 1, 3, "R5");

    cur_req = "R9";
    cpu_ack = 2'b01; #1;
    expect_bit(cpu_ack_ok[0], 1, "R9 ack_ok");
    step(1); cpu_ack = '0;
    expect_cand(0, 0, 0, "R9");

    cur_req = "R11";
    eoi(1, 3);  // cpu1 copy not active: no effect
    expect_cand(1, 1, 3, "R11");
    expect_cand(0, 0, 0, "R11");
    eoi(0, 3);
    expect_cand(0, 0, 0, "R11");
    ack(2'b10);
    eoi(1, 3);
    expect_cand(1, 0, 0, "R11");

    cur_req = "R6";
    wr(1, 20, 1);
    wr(2, 20, 8'h30);
    ppi_n[16+4] = 0; step(1);
    expect_cand(1, 1, 20, "R6");
    expect_cand(0, 0, 0, "R6");
    ppi_n[16+4] = 1; step(1);
    expect_cand(1, 0, 0, "R6");

    cur_req = "R4";
    wr(1, 40, 1); wr(1, 41, 1); wr(1, 45, 1);
    wr(5, 40, 1); wr(5, 41, 1); wr(5, 45, 1);
    wr(2, 40, 8'h10); wr(2, 41, 8'h10); wr(2, 45, 8'h08);
    spi_in[8] = 1; spi_in[9] = 1; spi_in[13] = 1; step(1);
    expect_cand(0, 1, 45, "R4");
    expect_cand(1, 0, 0, "R8");
    wr(2, 45, 8'h20);
    expect_cand(0, 1, 40, "R4 tie");

    cur_req = "R3";
    wr(1, 40, 0);
    expect_cand(0, 1, 41, "R3");

    cur_req = "R13";
    wr(4, 41, 1);
    expect_bit(cpu_grp[0], 1, "R13");

    cur_req = "R2";
    wr(0, 0, 0);
    expect_cand(0, 0, 0, "R2");
    wr(0, 0, 1);
    expect_cand(0, 1, 41, "R2");

    cur_req = "R7";
    spi_in = '0; step(1);
    expect_cand(0, 0, 0, "R7 level");
    wr(1, 50, 1); wr(2, 50, 8'h20); wr(5, 50, 2'b10); wr(3, 50, 1);
    wr(3, 5, 1);  // ignored on a private ID
    pulse_spi(18); step(1);
    expect_cand(1, 1, 50, "R7 edge");
    expect_cand(0, 0, 0, "R8");
    wr(7, 50, 0);
    expect_cand(1, 0, 0, "R7 clear");

    cur_req = "R10";
    pulse_spi(18);
    expect_cand(1, 1, 50, "R10");
    ack(2'b10);
    expect_cand(1, 0, 0, "R10");
    pulse_spi(18);
    expect_cand(1, 0, 0, "R10 act+pend");
    eoi(1, 50);
    expect_cand(1, 1, 50, "R10 repend");
    ack(2'b10);
    eoi(1, 50);
    expect_cand(1, 0, 0, "R10");

    cur_req = "R12";
    wr(1, 52, 1); wr(2, 52, 8'h05); wr(5, 52, 2'b11); wr(3, 52, 1);
    pulse_spi(20);
    expect_cand(0, 1, 52, "R12");
    expect_cand(1, 1, 52, "R12");
    cpu_ack = 2'b11; #1;
    expect_bit(cpu_ack_ok[0], 1, "R12 cpu0 wins");
    expect_bit(cpu_ack_ok[1], 0, "R12 cpu1 loses");
    step(1); cpu_ack = '0;
    expect_cand(0, 0, 0, "R12");
    expect_cand(1, 0, 0, "R12");
    eoi(0, 52);
    pulse_spi(20);
    ack(2'b10);
    expect_cand(0, 0, 0, "R12 withdrawn");
    eoi(1, 52);
    step(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule